// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block holds the two threshold offsets of a FIFO, one for the almost-empty condition and one for the almost-full condition. It also produces the two matching active-low flags from the word count that the FIFO core reports. It runs on the write clock. A strap sampled while master reset is asserted chooses two things together: the default value of both offsets, and the one programming method accepted until the next master reset.

In parallel mode, each strobed write (load strobe and write enable both low) copies the data bus into one offset register. The target alternates between the two registers. In serial mode, each strobed write clocks one bit from the serial input into the offsets, almost-empty first. Both offsets are always visible on readback outputs, whichever method is active.

Partial reset restarts the loading sequence and forces the flags to their reset levels. It keeps the offset values and the method selected at the last master reset.

Top module: `fifo_thresh_prog`

## Requirements
- R1: If `ld_strap` is 0 while `mrst_n` is low, both offsets reset to 127 (0x07F) and parallel loading is the only method accepted afterwards.
- R2: If `ld_strap` is 1 while `mrst_n` is low, both offsets reset to 1023 (0x3FF) and serial loading is the only method accepted afterwards.
- R3: In parallel mode, a rising `clk` edge with `ld_n`=0 and `wr_n`=0 loads `din` into the almost-empty offset on the first strobed write after a reset and into the almost-full offset on the second. Later strobed writes keep alternating between the two, starting again with almost-empty.
- R4: In serial mode, each rising `clk` edge with `ld_n`=0 and `wr_n`=0 takes one bit from `ser_in`, LSB first. The first OFS_W bits fill the almost-empty offset and the next OFS_W bits fill the almost-full offset. The sequence then starts again at the almost-empty offset.
- R5: `ae_ofs` and `af_ofs` always show the current offset values, in both modes.
- R6: While `mrst_n` or `prst_n` is low, `ae_n` is 0 and `af_n` is 1.
- R7: Partial reset leaves both offsets and the selected method unchanged, and makes the next strobed write start again at the almost-empty offset.
- R8: One clock after `wcount` is applied, `ae_n` is 0 when `wcount` is less than or equal to the almost-empty offset, and 1 otherwise.
- R9: One clock after `wcount` is applied, `af_n` is 0 when DEPTH minus `wcount` is less than or equal to the almost-full offset, and 1 otherwise.
- R10: An edge with `ld_n`=1 or `wr_n`=1 changes no offset. A strobed write that uses the method not selected at master reset also changes no offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| prst_n | input | 1 | Asynchronous partial reset, active low |
| ld_strap | input | 1 | Method and default strap, sampled during master reset |
| ld_n | input | 1 | Offset load strobe, active low |
| wr_n | input | 1 | Write enable, active low |
| ser_in | input | 1 | Serial offset data bit |
| din | input | OFS_W | Parallel offset data |
| wcount | input | CNT_W | Current FIFO word count (0 to DEPTH) |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |
| ae_ofs | output | OFS_W | Almost-empty offset readback |
| af_ofs | output | OFS_W | Almost-full offset readback |

## Verification
The flag logic is driven by a table of word counts around both defaults: zero, exactly the offset, one above it, mid-range, the free space exactly at and one above the almost-full offset, and a full FIFO. This separates "at or below" from "strictly below". Parallel loading is exercised with three strobed writes of distinct values, which exposes a wrong register order or a missing alternation. Partial reset is placed where the load pointer sits on the almost-full register, so a pointer that is not restarted shows up. Serial loading uses asymmetric bit patterns (0x155 and 0x0AA, then 0x001), so that bit order, register order and wrap-around each give a distinct result. Strobes with only one of the two enables low, and strobes for the method that was not selected, show whether any offset moves when it should not.

// File: rtl/fifo_thresh_prog.sv
module fifo_thresh_prog #(
  parameter int DEPTH = 4096,
  parameter int OFS_W = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ld_strap,
  input  logic             ld_n,
  input  logic             wr_n,
  input  logic             ser_in,
  input  logic [OFS_W-1:0] din,
  input  logic [CNT_W-1:0] wcount,
  output logic             ae_n,
  output logic             af_n,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam int BIT_W = $clog2(2 * OFS_W);
  localparam logic [OFS_W-1:0] DEF_PAR = OFS_W'(127);
  localparam logic [OFS_W-1:0] DEF_SER = OFS_W'(1023);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(2 * OFS_W - 1);
  localparam logic [BIT_W-1:0] HALF_BIT = BIT_W'(OFS_W);

  logic             ser_mode;
  logic             par_sel;
  logic [BIT_W-1:0] bit_idx;
  logic             rst_any_n;
  logic             strobe;
  logic [CNT_W-1:0] free_cnt;

  assign rst_any_n = mrst_n & prst_n;
  assign strobe    = !ld_n && !wr_n && prst_n;
  assign free_cnt  = CNT_W'(DEPTH) - wcount;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      ser_mode <= ld_strap;
      ae_ofs   <= ld_strap ? DEF_SER : DEF_PAR;
      af_ofs   <= ld_strap ? DEF_SER : DEF_PAR;
    end else if (strobe) begin
      if (ser_mode) begin
        if (bit_idx < HALF_BIT) ae_ofs <= {ser_in, ae_ofs[OFS_W-1:1]};
        else                    af_ofs <= {ser_in, af_ofs[OFS_W-1:1]};
      end else begin
        if (!par_sel) ae_ofs <= din;
        else          af_ofs <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      par_sel <= 1'b0;
      bit_idx <= '0;
      ae_n    <= 1'b0;
      af_n    <= 1'b1;
    end else begin
      ae_n <= !(wcount <= CNT_W'(ae_ofs));
      af_n <= !(free_cnt <= CNT_W'(af_ofs));
      if (strobe) begin
        if (ser_mode) bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
        else          par_sel <= !par_sel;
      end
    end
  end
endmodule

// File: rtl/fifo_thresh_prog_chk.sv
module fifo_thresh_prog_chk #(
  parameter int OFS_W = 10,
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             prst_n,
  input logic             ld_n,
  input logic             wr_n,
  input logic             ser_mode,
  input logic [CNT_W-1:0] wcount,
  input logic             ae_n,
  input logic             af_n,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs
);
  a_r1_r2_defaults: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(mrst_n) |-> (ser_mode ? (ae_ofs == OFS_W'(1023) && af_ofs == OFS_W'(1023))
                                : (ae_ofs == OFS_W'(127)  && af_ofs == OFS_W'(127))));

  a_r6_flags_after_prst: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(prst_n) |-> (!ae_n && af_n));

  a_r7_prst_keeps_offsets: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_ofs) && $stable(af_ofs)));

  a_r7_mode_fixed: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> $stable(ser_mode));

  a_r10_no_strobe_no_load: assert property (@(posedge clk) disable iff (!mrst_n)
    (ld_n || wr_n) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  a_r8_ae_flag: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    prst_n |=> (ae_n == ($past(wcount) > CNT_W'($past(ae_ofs)))));
endmodule

bind fifo_thresh_prog fifo_thresh_prog_chk #(.OFS_W(OFS_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n), .wr_n(wr_n),
  .ser_mode(ser_mode), .wcount(wcount), .ae_n(ae_n), .af_n(af_n),
  .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/test_fifo_thresh_prog.sv
module test_fifo_thresh_prog;
  localparam int DEPTH = 4096;
  localparam int OFS_W = 10;
  localparam int CNT_W = 13;

  logic             clk = 1'b0;
  logic             mrst_n = 1'b0;
  logic             prst_n = 1'b1;
  logic             ld_strap = 1'b0;
  logic             ld_n = 1'b1;
  logic             wr_n = 1'b1;
  logic             ser_in = 1'b0;
  logic [OFS_W-1:0] din = '0;
  logic [CNT_W-1:0] wcount = '0;
  logic             ae_n, af_n;
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fifo_thresh_prog #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_fifo_thresh_prog (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_strap(ld_strap),
    .ld_n(ld_n), .wr_n(wr_n), .ser_in(ser_in), .din(din), .wcount(wcount),
    .ae_n(ae_n), .af_n(af_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  // {wcount, expected ae_n, expected af_n} with both offsets at 127
  localparam logic [14:0] VEC [7] = '{
    {13'd0,    1'b0, 1'b1},
    {13'd127,  1'b0, 1'b1},
    {13'd128,  1'b1, 1'b1},
    {13'd2000, 1'b1, 1'b1},
    {13'd3968, 1'b1, 1'b1},
    {13'd3969, 1'b1, 1'b0},
    {13'd4096, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic l, input logic w, input logic [OFS_W-1:0] d, input logic s);
    @(negedge clk);
    ld_n = l; wr_n = w; din = d; ser_in = s;
    @(negedge clk);
    ld_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic shift_word(input logic [OFS_W-1:0] v);
    for (int i = 0; i < OFS_W; i++) begin
      @(negedge clk);
      ld_n = 1'b0; wr_n = 1'b0; ser_in = v[i];
    end
    @(negedge clk);
    ld_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic set_count(input int c);
    @(negedge clk);
    wcount = CNT_W'(c);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 ae_n in master reset", int'(ae_n), 0);
    chk("R6 af_n in master reset", int'(af_n), 1);
    mrst_n = 1'b1;
    @(negedge clk);
    chk("R1 ae default", int'(ae_ofs), 127);
    chk("R1 af default", int'(af_ofs), 127);

    for (int k = 0; k < 7; k++) begin
      set_count(int'(VEC[k][14:2]));
      chk("R8 ae_n table", int'(ae_n), int'(VEC[k][1]));
      chk("R9 af_n table", int'(af_n), int'(VEC[k][0]));
    end

    strobe(1'b0, 1'b1, 10'd99, 1'b0);
    strobe(1'b1, 1'b0, 10'd98, 1'b0);
    chk("R10 no load ae", int'(ae_ofs), 127);
    chk("R10 no load af", int'(af_ofs), 127);

    strobe(1'b0, 1'b0, 10'd5, 1'b0);
    chk("R3 first write ae", int'(ae_ofs), 5);
    chk("R3 first write af unchanged", int'(af_ofs), 127);
    strobe(1'b0, 1'b0, 10'd20, 1'b0);
    chk("R3 second write af", int'(af_ofs), 20);
    strobe(1'b0, 1'b0, 10'd7, 1'b0);
    chk("R3 third write ae", int'(ae_ofs), 7);
    chk("R5 readback af", int'(af_ofs), 20);

    set_count(7);
    chk("R8 ae at offset", int'(ae_n), 0);
    set_count(8);
    chk("R8 ae above offset", int'(ae_n), 1);
    set_count(4076);
    chk("R9 af free at offset", int'(af_n), 0);
    set_count(4075);
    chk("R9 af free above offset", int'(af_n), 1);

    @(negedge clk);
    prst_n = 1'b0;
    @(negedge clk);
    chk("R6 ae_n in partial reset", int'(ae_n), 0);
    chk("R6 af_n in partial reset", int'(af_n), 1);
    prst_n = 1'b1;
    @(negedge clk);
    chk("R7 ae kept", int'(ae_ofs), 7);
    chk("R7 af kept", int'(af_ofs), 20);
    strobe(1'b0, 1'b0, 10'd9, 1'b0);
    chk("R7 sequence restarts at ae", int'(ae_ofs), 9);
    chk("R7 af untouched", int'(af_ofs), 20);

    @(negedge clk);
    mrst_n = 1'b0; ld_strap = 1'b1;
    @(negedge clk);
    mrst_n = 1'b1;
    @(negedge clk);
    ld_strap = 1'b0;
    chk("R2 ae default", int'(ae_ofs), 1023);
    chk("R2 af default", int'(af_ofs), 1023);
    strobe(1'b0, 1'b1, 10'd3, 1'b0);
    strobe(1'b1, 1'b0, 10'd3, 1'b0);
    chk("R10 serial idle ae", int'(ae_ofs), 1023);

    shift_word(10'h155);
    chk("R4 ae serial", int'(ae_ofs), 'h155);
    chk("R4 af untouched", int'(af_ofs), 1023);
    shift_word(10'h0AA);
    chk("R4 af serial", int'(af_ofs), 'h0AA);
    chk("R5 readback ae serial", int'(ae_ofs), 'h155);
    shift_word(10'h001);
    chk("R4 wrap to ae", int'(ae_ofs), 1);

    @(negedge clk);
    prst_n = 1'b0;
    @(negedge clk);
    prst_n = 1'b1;
    shift_word(10'h2F0);
    chk("R7 serial kept after partial reset", int'(ae_ofs), 'h2F0);
    chk("R7 af kept serial", int'(af_ofs), 'h0AA);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule